// File: doc/BRIEF.md
# Pause and Priority-Pause Request Sequencer

This block exercises the flow-control transmit path of a MAC once a packet-generation run has finished. A single-cycle start pulse launches the sequence. The block first asks the MAC to send a link-wide pause by driving the global enable and request bit, which is the top bit of both 9-bit vectors. It holds that request until the MAC reports that the pause frame has gone out. It then switches to per-priority pause. It enables the eight lower classes and requests them one at a time, starting at the highest class and ending at class 0. After each request it waits for the matching per-class status bit.

When the last class is acknowledged, the block clears every enable and request bit and raises a one-cycle completion flag. A watchdog counter bounds each wait. If a status never arrives, the block jumps to the clearing step and sets a sticky error flag. If the link loses alignment at any time, the block drops all outputs and returns to idle without reporting completion.

Top module: `pause_seq`

## Requirements
- R1: During and right after reset, `pause_en_o` and `pause_req_o` are zero, and `busy_o`, `done_o` and `timeout_err_o` are low.
- R2: In idle, a high `start_i` sampled while `link_aligned_i` is high makes the next cycle drive `pause_en_o` = 9'h100 and `pause_req_o` = 9'h100, with `busy_o` high. A start sampled while the link is unaligned or while `busy_o` is high has no effect.
- R3: The global request (bit 8) stays asserted until `tx_pause_sent_i` is sampled high. The next cycle drives `pause_en_o` = 9'h0FF and `pause_req_o` = 9'h080.
- R4: In the priority phase `pause_req_o` has at most one bit set, and classes are requested in the order 7, 6, …, 0. Each request holds until `tx_prio_valid_i` bit k of that same class is sampled high. A status bit of any other class is ignored.
- R5: After class k > 0 is acknowledged, exactly one cycle follows with `pause_req_o` = 0 and `pause_en_o` still 9'h0FF. Then class k−1 is requested.
- R6: One cycle after class 0 is acknowledged, `pause_en_o` and `pause_req_o` are zero and `done_o` is high for exactly one cycle. The following cycle `busy_o` is low.
- R7: A waiting step (global, or any class request) whose status stays low for TIMEOUT_CYCLES cycles moves to the clearing cycle (`done_o` high, outputs zero) and sets `timeout_err_o`. A status that arrives in the last allowed cycle wins, and no error is set.
- R8: `timeout_err_o` stays high until the next accepted start, which clears it.
- R9: A low `link_aligned_i` in any cycle makes the next cycle idle, with both vectors zero, `busy_o` low and no `done_o`.
- R10: Every set bit of `pause_req_o` is also set in `pause_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse from the packet generator |
| link_aligned_i | input | 1 | Link alignment status; low aborts to idle |
| tx_pause_sent_i | input | 1 | MAC status: global pause frame transmitted |
| tx_prio_valid_i | input | 8 | MAC status: per-class pause frame transmitted |
| pause_en_o | output | 9 | Pause enable vector (bit 8 global, 7..0 classes) |
| pause_req_o | output | 9 | Pause request vector (bit 8 global, 7..0 classes) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion flag |
| timeout_err_o | output | 1 | Sticky flag: a status wait timed out |

## Verification
Two mechanisms can resolve in the same cycle: the watchdog expiring and the awaited MAC status arriving. The bench counts cycles from the start of the global wait. It raises `tx_pause_sent_i` exactly in the final cycle the watchdog allows, then checks that the class-7 request follows with `timeout_err_o` still low, as R7 requires. The same wait is also run one cycle longer without the status, to show the expiry path on its own.

// File: rtl/pause_seq_pkg.sv
// Package: shared state encoding for the pause request sequencer.
// Assumes: all sequencer submodules import this package.
package pause_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,  // waiting for a start pulse
        ST_GLOBAL   = 3'd1,  // global pause requested, waiting for sent status
        ST_PRIO_REQ = 3'd2,  // one class requested, waiting for its status
        ST_PRIO_GAP = 3'd3,  // one idle cycle between class requests
        ST_CLEAR    = 3'd4   // outputs cleared, completion reported
    } seq_state_t;

endpackage

// File: rtl/pause_seq_timer.sv
// Module: wait watchdog. Counts the cycles spent in the current state and
// flags expiry once the state has lasted LIMIT cycles.
// Assumes: clr_i is high on every edge where the controller changes state.
module pause_seq_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);

    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count up from zero on state entry and saturate at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Expiry is the last cycle of the allowed window.
    assign expired_o = (cnt_q == LAST);

endmodule

// File: rtl/pause_seq_ctrl.sv
// Module: sequencing controller. Walks the global -> per-class order,
// tracks the current class, and keeps the sticky timeout flag.
// Assumes: status inputs are synchronous to clk; a status that arrives in the
// same cycle as watchdog expiry takes precedence.
module pause_seq_ctrl
    import pause_seq_pkg::*;
#(
    parameter int NUM_PRIO = 8,
    parameter int IDX_W    = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                link_aligned_i,
    input  logic                tx_pause_sent_i,
    input  logic [NUM_PRIO-1:0] prio_valid_i,
    input  logic                expired_i,
    output seq_state_t          state_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                tmr_clr_o,
    output logic                err_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_PRIO - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             err_q, err_set, run_accept;

    // Next-state and class-index selection; link loss overrides all.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        err_set = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_GLOBAL;
            end
            ST_GLOBAL: begin
                if (tx_pause_sent_i) begin
                    state_d = ST_PRIO_REQ;
                    idx_d   = TOP_IDX;
                end else if (expired_i) begin
                    state_d = ST_CLEAR;
                    err_set = 1'b1;
                end
            end
            ST_PRIO_REQ: begin
                if (prio_valid_i[idx_q]) begin
                    state_d = (idx_q == '0) ? ST_CLEAR : ST_PRIO_GAP;
                end else if (expired_i) begin
                    state_d = ST_CLEAR;
                    err_set = 1'b1;
                end
            end
            ST_PRIO_GAP: begin
                state_d = ST_PRIO_REQ;
                idx_d   = idx_q - IDX_W'(1);
            end
            ST_CLEAR: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (!link_aligned_i) begin
            state_d = ST_IDLE;
            err_set = 1'b0;
        end
    end

    // A run is accepted when idle moves to the global step.
    assign run_accept = (state_q == ST_IDLE) && (state_d == ST_GLOBAL);

    // State and class-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Sticky timeout flag, cleared only by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (run_accept) begin
            err_q <= 1'b0;
        end
    end

    assign state_o   = state_q;
    assign idx_o     = idx_q;
    assign tmr_clr_o = (state_d != state_q);
    assign err_o     = err_q;

endmodule

// File: rtl/pause_seq_drive.sv
// Module: output decoder. Maps the controller state and class index onto
// the enable/request vectors and the busy/done flags.
// Assumes: the global bit sits above the NUM_PRIO class bits.
module pause_seq_drive
    import pause_seq_pkg::*;
#(
    parameter int NUM_PRIO = 8,
    parameter int IDX_W    = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1,
    parameter int VEC_W    = NUM_PRIO + 1
) (
    input  seq_state_t       state_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [VEC_W-1:0] pause_en_o,
    output logic [VEC_W-1:0] pause_req_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [VEC_W-1:0] EN_GLOBAL = {1'b1, {NUM_PRIO{1'b0}}};
    localparam logic [VEC_W-1:0] EN_CLASS  = {1'b0, {NUM_PRIO{1'b1}}};

    logic [NUM_PRIO-1:0] class_req;

    // One request line per class, set only for the selected class.
    for (genvar g = 0; g < NUM_PRIO; g++) begin : g_class_req
        assign class_req[g] = (state_i == ST_PRIO_REQ) && (idx_i == IDX_W'(g));
    end

    // Enable vector by phase.
    always_comb begin
        case (state_i)
            ST_GLOBAL:                pause_en_o = EN_GLOBAL;
            ST_PRIO_REQ, ST_PRIO_GAP: pause_en_o = EN_CLASS;
            default:                  pause_en_o = '0;
        endcase
    end

    assign pause_req_o = {state_i == ST_GLOBAL, class_req};
    assign busy_o      = (state_i != ST_IDLE);
    assign done_o      = (state_i == ST_CLEAR);

endmodule

// File: rtl/pause_seq.sv
// Module: pause and per-class pause request sequencer (top).
// Connects the controller, watchdog and output decoder.
// Assumes: start_i is a pulse from the packet generator; MAC status inputs
// are synchronous to clk.
module pause_seq
    import pause_seq_pkg::*;
#(
    parameter int NUM_PRIO       = 8,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                link_aligned_i,
    input  logic                tx_pause_sent_i,
    input  logic [NUM_PRIO-1:0] tx_prio_valid_i,
    output logic [NUM_PRIO:0]   pause_en_o,
    output logic [NUM_PRIO:0]   pause_req_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                timeout_err_o
);

    localparam int IDX_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;
    localparam int VEC_W = NUM_PRIO + 1;

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             tmr_clr, expired;

    // Sequencing controller.
    pause_seq_ctrl #(.NUM_PRIO(NUM_PRIO), .IDX_W(IDX_W)) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .link_aligned_i  (link_aligned_i),
        .tx_pause_sent_i (tx_pause_sent_i),
        .prio_valid_i    (tx_prio_valid_i),
        .expired_i       (expired),
        .state_o         (state),
        .idx_o           (idx),
        .tmr_clr_o       (tmr_clr),
        .err_o           (timeout_err_o)
    );

    // Per-state wait watchdog.
    pause_seq_timer #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .expired_o (expired)
    );

    // Output decode.
    pause_seq_drive #(.NUM_PRIO(NUM_PRIO), .IDX_W(IDX_W), .VEC_W(VEC_W)) drive_i (
        .state_i     (state),
        .idx_i       (idx),
        .pause_en_o  (pause_en_o),
        .pause_req_o (pause_req_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/pause_seq_chk.sv
// Module: property checker for the pause sequencer, bound to every instance.
// Assumes: observes ports only; reset is synchronous active low.
module pause_seq_chk #(
    parameter int NUM_PRIO = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                link_aligned_i,
    input logic                tx_pause_sent_i,
    input logic [NUM_PRIO:0]   pause_en_o,
    input logic [NUM_PRIO:0]   pause_req_o,
    input logic                busy_o,
    input logic                done_o,
    input logic                timeout_err_o
);

    localparam logic [NUM_PRIO:0] GLOBAL_VEC = {1'b1, {NUM_PRIO{1'b0}}};

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pause_req_o)); // R4

    AST_REQ_WITHIN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req_o & ~pause_en_o) == '0); // R10

    AST_START_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && link_aligned_i && !busy_o) |=> (pause_req_o == GLOBAL_VEC)); // R2

    AST_GLOBAL_TO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req_o[NUM_PRIO] && tx_pause_sent_i && link_aligned_i)
            |=> pause_req_o[NUM_PRIO-1]); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pause_en_o == '0 && pause_req_o == '0)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err_o && !(start_i && link_aligned_i && !busy_o))
            |=> timeout_err_o); // R8

    AST_LINK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !link_aligned_i |=> (!busy_o && !done_o && pause_en_o == '0
                             && pause_req_o == '0)); // R9

endmodule

bind pause_seq pause_seq_chk #(.NUM_PRIO(NUM_PRIO)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .link_aligned_i  (link_aligned_i),
    .tx_pause_sent_i (tx_pause_sent_i),
    .pause_en_o      (pause_en_o),
    .pause_req_o     (pause_req_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .timeout_err_o   (timeout_err_o)
);

// File: tb/pause_seq_tb_top.sv
// Directed bench for the pause sequencer: one task per scenario.
module pause_seq_tb_top;

    localparam int NP  = 8;
    localparam int TMO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          link_aligned_i = 1'b1;
    logic          tx_pause_sent_i = 1'b0;
    logic [NP-1:0] tx_prio_valid_i = '0;
    logic [NP:0]   pause_en_o, pause_req_o;
    logic          busy_o, done_o, timeout_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    pause_seq #(.NUM_PRIO(NP), .TIMEOUT_CYCLES(TMO)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .link_aligned_i  (link_aligned_i),
        .tx_pause_sent_i (tx_pause_sent_i),
        .tx_prio_valid_i (tx_prio_valid_i),
        .pause_en_o      (pause_en_o),
        .pause_req_o     (pause_req_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .timeout_err_o   (timeout_err_o)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Advance one edge and settle away from it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare {en, req, busy, done} as one word.
    task automatic chk_out(input string tag, input logic [8:0] en, input logic [8:0] req,
                           input logic busy, input logic done);
        chk(tag, {12'b0, pause_en_o, pause_req_o, busy_o, done_o},
                 {12'b0, en, req, busy, done});
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    task automatic abort_to_idle();
        link_aligned_i = 1'b0;
        tick();
        link_aligned_i = 1'b1;
        tick();
    endtask

    // Start and reach the class-7 request.
    task automatic run_to_class(input string tag);
        pulse_start();
        chk_out({tag, " R2 global"}, 9'h100, 9'h100, 1'b1, 1'b0);
        tx_pause_sent_i = 1'b1;
        tick();
        tx_pause_sent_i = 1'b0;
        chk_out({tag, " R3 class7"}, 9'h0FF, 9'h080, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk_out("R1 in reset", 9'h0, 9'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();
        chk_out("R1 after reset", 9'h0, 9'h0, 1'b0, 1'b0);
        chk("R1 err after reset", {31'b0, timeout_err_o}, 32'h0);
    endtask

    task automatic t_full_run();
        pulse_start();
        chk_out("R2 global", 9'h100, 9'h100, 1'b1, 1'b0);
        repeat (3) tick();
        chk_out("R3 global held", 9'h100, 9'h100, 1'b1, 1'b0);
        tx_pause_sent_i = 1'b1;
        tick();
        tx_pause_sent_i = 1'b0;
        for (int k = NP - 1; k >= 0; k--) begin
            chk_out("R4 class request", 9'h0FF, 9'(1 << k), 1'b1, 1'b0);
            chk("R10 req within en", {23'b0, pause_req_o & ~pause_en_o}, 32'h0);
            if (k == NP - 1) begin
                tx_prio_valid_i = 8'h08;
                tick();
                tx_prio_valid_i = '0;
                chk_out("R4 foreign status ignored", 9'h0FF, 9'h080, 1'b1, 1'b0);
            end
            tx_prio_valid_i[k] = 1'b1;
            tick();
            tx_prio_valid_i = '0;
            if (k > 0) begin
                chk_out("R5 gap cycle", 9'h0FF, 9'h0, 1'b1, 1'b0);
                tick();
            end else begin
                chk_out("R6 clear and done", 9'h0, 9'h0, 1'b1, 1'b1);
                tick();
                chk_out("R6 back to idle", 9'h0, 9'h0, 1'b0, 1'b0);
            end
        end
        chk("R7 no error on clean run", {31'b0, timeout_err_o}, 32'h0);
    endtask

    task automatic t_ignored_starts();
        link_aligned_i = 1'b0;
        pulse_start();
        link_aligned_i = 1'b1;
        chk_out("R2 start without link ignored", 9'h0, 9'h0, 1'b0, 1'b0);
        run_to_class("busy");
        pulse_start();
        chk_out("R2 start while busy ignored", 9'h0FF, 9'h080, 1'b1, 1'b0);
        abort_to_idle();
    endtask

    task automatic t_race();
        pulse_start();
        repeat (TMO - 1) tick();
        chk_out("R7 last allowed cycle", 9'h100, 9'h100, 1'b1, 1'b0);
        tx_pause_sent_i = 1'b1;
        tick();
        tx_pause_sent_i = 1'b0;
        chk_out("R7 status wins over expiry", 9'h0FF, 9'h080, 1'b1, 1'b0);
        chk("R7 no error on race", {31'b0, timeout_err_o}, 32'h0);
        abort_to_idle();
    endtask

    task automatic t_global_timeout();
        pulse_start();
        repeat (TMO - 1) tick();
        chk_out("R7 global still waiting", 9'h100, 9'h100, 1'b1, 1'b0);
        tick();
        chk_out("R7 global timeout clears", 9'h0, 9'h0, 1'b1, 1'b1);
        chk("R7 global timeout err", {31'b0, timeout_err_o}, 32'h1);
        tick();
        chk_out("R7 idle after timeout", 9'h0, 9'h0, 1'b0, 1'b0);
        repeat (3) tick();
        chk("R8 err sticky in idle", {31'b0, timeout_err_o}, 32'h1);
        link_aligned_i = 1'b0;
        pulse_start();
        link_aligned_i = 1'b1;
        chk("R8 err kept on refused start", {31'b0, timeout_err_o}, 32'h1);
        pulse_start();
        chk("R8 err cleared by accepted start", {31'b0, timeout_err_o}, 32'h0);
        abort_to_idle();
    endtask

    task automatic t_class_timeout();
        run_to_class("ctmo");
        repeat (TMO - 1) tick();
        chk_out("R7 class still waiting", 9'h0FF, 9'h080, 1'b1, 1'b0);
        tick();
        chk_out("R7 class timeout clears", 9'h0, 9'h0, 1'b1, 1'b1);
        chk("R7 class timeout err", {31'b0, timeout_err_o}, 32'h1);
        tick();
        pulse_start();
        abort_to_idle();
    endtask

    task automatic t_link_loss();
        run_to_class("link");
        for (int k = NP - 1; k > 5; k--) begin
            tx_prio_valid_i[k] = 1'b1;
            tick();
            tx_prio_valid_i = '0;
            tick();
        end
        chk_out("R4 reached class5", 9'h0FF, 9'h020, 1'b1, 1'b0);
        link_aligned_i = 1'b0;
        tick();
        chk_out("R9 abort to idle", 9'h0, 9'h0, 1'b0, 1'b0);
        link_aligned_i = 1'b1;
        tick();
        chk_out("R9 stays idle", 9'h0, 9'h0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full_run();
        t_ignored_starts();
        t_race();
        t_global_timeout();
        t_class_timeout();
        t_link_loss();
        t_full_run();
        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule